// File: doc/BRIEF.md
# Vector Multiply-Low-Add Execution Slice

This slice executes one three-source vector instruction. It holds its own 32-entry file of 128-bit vector registers. When the issue strobe is high, it takes a 32-bit instruction word and checks the opcode pair. It then reads three source registers and treats each value as eight 16-bit lanes. In every lane it multiplies A by B, keeps only the low 16 bits of the product, adds C, and wraps the sum to 16 bits. The 128-bit result is written to the destination register. No flag, saturation or status state exists, so overflow is silent.

Only one instruction is in flight at a time. The word is registered on the issue edge. In the following cycle the sources are read, the result is written at the end of that cycle, and either the done strobe or the illegal strobe is high. A test port can preload any register and read any register combinationally. This lets the surrounding logic or a bench set up operands and inspect results.

Top module: `vmla_slice`

## Requirements
- R1: For each lane, the result is (A × B + C) mod 2^16, using only the low 16 bits of the 32-bit product, with no rounding or saturation. For example, 0xFFFF × 0xFFFF + 0xFFFF gives 0x0000.
- R2: Lane 0 is bits [127:112] of a register, and lane 7 is bits [15:0].
- R3: The result bits are the same whether lanes are read as signed or unsigned. For example, A = 0xFFFF (−1), B = 5, C = 0 gives 0xFFFB.
- R4: Fields are numbered MSB-first. Word bits [31:26] are the primary opcode, [25:21] the destination, [20:16] source A, [15:11] source B, [10:6] source C and [5:0] the extended opcode. The instruction matches only when the primary opcode is 4 and the extended opcode is 34, so the word with all register fields zero is 0x10000022.
- R5: A non-matching word that is issued raises `illegal` for exactly one cycle, keeps `done` low, and leaves every register unchanged.
- R6: `done` (or `illegal`) is high in the cycle right after the issue strobe. The result can be read on the test port from the cycle after that.
- R7: The destination may equal any source. All three sources are read before the write, so `vD = vD × vB + vD` uses the old value of vD in both places.
- R8: After reset, `done` and `illegal` are low and every register reads zero.
- R9: A test-port write stores the data in the indexed register, and the test-port read shows a register's value combinationally. If an executing write and a test-port write happen in the same cycle, the executing write takes priority.
- R10: Issues in consecutive cycles are allowed, and an instruction reads the result written by the instruction issued one cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction strobe |
| issue_word | input | 32 | Instruction word |
| done | output | 1 | Result written this cycle |
| illegal | output | 1 | Issued word did not match |
| tp_wr_en | input | 1 | Test-port write enable |
| tp_wr_idx | input | 5 | Test-port write register |
| tp_wr_data | input | 128 | Test-port write data |
| tp_rd_idx | input | 5 | Test-port read register |
| tp_rd_data | output | 128 | Test-port read data |

## Verification
A table of lane patterns checks the arithmetic:
- All-ones lanes and 0x7FFF squared confirm that the product is truncated and the sum wraps.
- 0x0100 × 0x0100 confirms that the carry out of the low product is dropped.
- An all-lanes-different vector exposes any lane swap or reversed lane order.
- A −1 × 5 row confirms that the result does not depend on the sign view.

Pseudo-random operands, compared against a lane model in the bench, cover the general case. Directed runs then cover:
- the aliased accumulate form;
- words that differ from the match in only the extended or only the primary opcode;
- dependent back-to-back issue;
- a collision between a test-port write and an executing write.

// File: rtl/vmla_slice.sv
module vmla_slice #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int NREGS  = 32,
  parameter logic [5:0] PRI_OP = 6'd4,
  parameter logic [5:0] EXT_OP = 6'd34
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_valid,
  input  logic [31:0]              issue_word,
  output logic                     done,
  output logic                     illegal,
  input  logic                     tp_wr_en,
  input  logic [4:0]               tp_wr_idx,
  input  logic [LANES*LANE_W-1:0]  tp_wr_data,
  input  logic [4:0]               tp_rd_idx,
  output logic [LANES*LANE_W-1:0]  tp_rd_data
);
  localparam int VW = LANES * LANE_W;

  logic [VW-1:0] rf_q [NREGS];
  logic          pend_q;
  logic [31:0]   word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= issue_valid;
      if (issue_valid) word_q <= issue_word;
    end
  end

  // MSB-first field numbering: bit 0 of the word is word[31]
  logic [5:0] f_pri, f_ext;
  logic [4:0] f_dst, f_a, f_b, f_c;
  assign f_pri = word_q[31:26];
  assign f_dst = word_q[25:21];
  assign f_a   = word_q[20:16];
  assign f_b   = word_q[15:11];
  assign f_c   = word_q[10:6];
  assign f_ext = word_q[5:0];

  logic hit;
  assign hit     = (f_pri == PRI_OP) && (f_ext == EXT_OP);
  assign done    = pend_q && hit;
  assign illegal = pend_q && !hit;

  logic [VW-1:0] op_a, op_b, op_c, result;
  assign op_a = rf_q[f_a];
  assign op_b = rf_q[f_b];
  assign op_c = rf_q[f_c];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = VW - 1 - i * LANE_W;
    logic [LANE_W-1:0] prod_lo;
    // a LANE_W-wide product keeps only the low half
    assign prod_lo = op_a[HI -: LANE_W] * op_b[HI -: LANE_W];
    assign result[HI -: LANE_W] = prod_lo + op_c[HI -: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) rf_q[r] <= '0;
    end else if (done) begin
      rf_q[f_dst] <= result;
    end else if (tp_wr_en) begin
      rf_q[tp_wr_idx] <= tp_wr_data;
    end
  end

  assign tp_rd_data = rf_q[tp_rd_idx];

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal}));

  p_done_after_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done || illegal) |-> $past(issue_valid));

  p_illegal_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !tp_wr_en) |=> rf_q[$past(f_dst)] == $past(rf_q[f_dst]));

  p_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rf_q[$past(f_dst)] == $past(result));

  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue_valid) |-> $stable(word_q));
endmodule

// File: tb/vmla_slice_tb.sv
module vmla_slice_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_valid = 1'b0;
  logic [31:0]  issue_word = '0;
  logic         done, illegal;
  logic         tp_wr_en = 1'b0;
  logic [4:0]   tp_wr_idx = '0;
  logic [127:0] tp_wr_data = '0;
  logic [4:0]   tp_rd_idx = '0;
  logic [127:0] tp_rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmla_slice u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
    .done(done), .illegal(illegal), .tp_wr_en(tp_wr_en), .tp_wr_idx(tp_wr_idx),
    .tp_wr_data(tp_wr_data), .tp_rd_idx(tp_rd_idx), .tp_rd_data(tp_rd_data)
  );

  // stimulus rows: A, B, C, expected (R1, R2, R3)
  localparam logic [127:0] T_A [NT] = '{
    {8{16'h0002}}, {8{16'hFFFF}}, 128'h0001_0002_0003_0004_0005_0006_0007_0008,
    {8{16'hFFFF}}, {8{16'h0100}}, {8{16'h8000}}, {8{16'h7FFF}}};
  localparam logic [127:0] T_B [NT] = '{
    {8{16'h0003}}, {8{16'hFFFF}}, {8{16'h0010}},
    {8{16'h0005}}, {8{16'h0100}}, {8{16'h0002}}, {8{16'h7FFF}}};
  localparam logic [127:0] T_C [NT] = '{
    {8{16'h0001}}, {8{16'hFFFF}}, 128'h0,
    128'h0, {8{16'h1234}}, {8{16'h0001}}, 128'h0};
  localparam logic [127:0] T_E [NT] = '{
    {8{16'h0007}}, 128'h0, 128'h0010_0020_0030_0040_0050_0060_0070_0080,
    {8{16'hFFFB}}, {8{16'h1234}}, {8{16'h0001}}, {8{16'h0001}}};

  function automatic logic [31:0] mk(input logic [5:0] pri, input logic [4:0] d,
      input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input logic [5:0] x);
    return {pri, d, a, b, c, x};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] c);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] p;
      p = {16'h0, a[127-16*i -: 16]} * {16'h0, b[127-16*i -: 16]};
      r[127-16*i -: 16] = p[15:0] + c[127-16*i -: 16];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [4:0] idx, input logic [127:0] d);
    @(negedge clk);
    tp_wr_en = 1'b1; tp_wr_idx = idx; tp_wr_data = d;
    @(negedge clk);
    tp_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] idx, output logic [127:0] d);
    tp_rd_idx = idx;
    #1 d = tp_rd_data;
  endtask

  // issue one word; returns flags seen in the cycle after the strobe
  task automatic issue(input logic [31:0] w, output logic dn, output logic il);
    @(negedge clk);
    issue_valid = 1'b1; issue_word = w;
    @(negedge clk);
    issue_valid = 1'b0;
    dn = done; il = illegal;
    @(negedge clk);
  endtask

  localparam logic [31:0] OPW = 32'h1000_0022;

  initial begin
    logic [127:0] v, x, y, z, a1, b1;
    logic dn, il;
    logic [127:0] seed;

    repeat (3) @(negedge clk);
    chk("R8 done at reset", {127'h0, done}, 128'h0);
    chk("R8 illegal at reset", {127'h0, illegal}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 32; r += 7) begin
      peek(r[4:0], v);
      chk("R8 register zero after reset", v, 128'h0);
    end

    // R9 test port round trip
    poke(5'd9, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F0F_F0F0);
    peek(5'd9, v);
    chk("R9 test port round trip", v, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F0F_F0F0);

    // R4 canonical word with all register fields zero: v0 = v0*v0+v0
    poke(5'd0, {8{16'h0003}});
    issue(OPW, dn, il);
    chk("R4 canonical word done", {127'h0, dn}, 128'h1);
    peek(5'd0, v);
    chk("R4 canonical word result", v, {8{16'h000C}});

    for (int t = 0; t < NT; t++) begin
      poke(5'd1, T_A[t]); poke(5'd2, T_B[t]); poke(5'd3, T_C[t]);
      issue(mk(6'd4, 5'd4, 5'd1, 5'd2, 5'd3, 6'd34), dn, il);
      chk("R6 done one cycle after strobe", {126'h0, dn, il}, 128'h2);
      peek(5'd4, v);
      chk("R1/R2/R3 table row", v, T_E[t]);
    end

    seed = 128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978;
    for (int k = 0; k < 12; k++) begin
      x = seed; seed = {seed[126:0], seed[127] ^ seed[125] ^ seed[100] ^ seed[98]} * 128'd5 + 128'd7;
      y = seed; seed = {seed[126:0], seed[127] ^ seed[125] ^ seed[100] ^ seed[98]} * 128'd5 + 128'd7;
      z = seed; seed = {seed[126:0], seed[127] ^ seed[125] ^ seed[100] ^ seed[98]} * 128'd5 + 128'd7;
      poke(5'd10, x); poke(5'd20, y); poke(5'd30, z);
      issue(mk(6'd4, 5'd17, 5'd10, 5'd20, 5'd30, 6'd34), dn, il);
      peek(5'd17, v);
      chk("R1 random operands", v, model(x, y, z));
    end

    // R7 aliased accumulate: v3 = v3*v4 + v3
    a1 = 128'h0003_FFFF_8000_0010_1234_0001_7FFF_ABCD;
    b1 = 128'h0005_0002_0002_1000_0100_FFFF_0003_0007;
    poke(5'd3, a1); poke(5'd4, b1);
    issue(mk(6'd4, 5'd3, 5'd3, 5'd4, 5'd3, 6'd34), dn, il);
    peek(5'd3, v);
    chk("R7 aliased accumulate", v, model(a1, b1, a1));

    // R5 extended opcode mismatch
    poke(5'd6, 128'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_5555);
    issue(mk(6'd4, 5'd6, 5'd1, 5'd2, 5'd3, 6'd35), dn, il);
    chk("R5 ext mismatch flags", {126'h0, dn, il}, 128'h1);
    chk("R5 illegal lasts one cycle", {127'h0, illegal}, 128'h0);
    peek(5'd6, v);
    chk("R5 no write on ext mismatch", v, 128'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_5555);
    // R5 primary opcode mismatch
    issue(mk(6'd5, 5'd6, 5'd1, 5'd2, 5'd3, 6'd34), dn, il);
    chk("R5 primary mismatch flags", {126'h0, dn, il}, 128'h1);
    peek(5'd6, v);
    chk("R5 no write on primary mismatch", v, 128'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_5555);

    // R10 dependent back-to-back: v7 = 2*3+1 = 7, then v8 = v7*v7+v0
    poke(5'd1, {8{16'h0002}}); poke(5'd2, {8{16'h0003}}); poke(5'd3, {8{16'h0001}});
    poke(5'd0, 128'h0);
    @(negedge clk);
    issue_valid = 1'b1; issue_word = mk(6'd4, 5'd7, 5'd1, 5'd2, 5'd3, 6'd34);
    @(negedge clk);
    issue_word = mk(6'd4, 5'd8, 5'd7, 5'd7, 5'd0, 6'd34);
    chk("R10 first done", {127'h0, done}, 128'h1);
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R10 second done", {127'h0, done}, 128'h1);
    @(negedge clk);
    peek(5'd8, v);
    chk("R10 dependent result", v, {8{16'h0031}});

    // R9 priority: test-port write to the same register during writeback
    @(negedge clk);
    issue_valid = 1'b1; issue_word = mk(6'd4, 5'd11, 5'd1, 5'd2, 5'd3, 6'd34);
    @(negedge clk);
    issue_valid = 1'b0;
    tp_wr_en = 1'b1; tp_wr_idx = 5'd11; tp_wr_data = {8{16'hBEEF}};
    @(negedge clk);
    tp_wr_en = 1'b0;
    peek(5'd11, v);
    chk("R9 execute write wins collision", v, {8{16'h0007}});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule